// File: doc/BRIEF.md
# Dual LED Blink Pattern Generator

This block drives two indicator LEDs, a power LED and a suspend LED, from one shared slow time base. Each LED either follows a fixed hardware pattern derived from the current sleep state, or, when software programming is enabled, follows its own 3-bit pattern code taken from a control word. The patterns are steady low, released, and 50% duty square waves at three rates (1 Hz, 0.5 Hz, 0.25 Hz).

A prescaler divides the core clock down to a half-second tick (`TICK_DIV` cycles). A 3-bit phase counter advances on every tick, and its bits are the three blink waves, so all rates stay phase-aligned. Output levels are registered only on a tick. A change to the control word or the sleep state therefore appears at the next tick and never as a short glitch. A parameter selects open-drain or push-pull pad behaviour for the release level.

Top module: `led_blink_gen`

## Requirements
- R1: After reset and until the first tick, both LEDs are released, and the tick counter k (ticks since reset) is 0.
- R2: With ctrl_i[6]=0 (hardware mode), the power LED is low in state 2'b00, follows the 1 Hz wave in state 2'b01, and is released in states 2'b10 and 2'b11.
- R3: In hardware mode, the suspend LED level is always the complement of the power LED level.
- R4: With ctrl_i[6]=1, the power LED follows the code in ctrl_i[5:3] and the suspend LED follows the code in ctrl_i[2:0].
- R5: Code 3'b111 releases the LED. Codes 3'b000, 3'b001, 3'b010 and 3'b011 drive it low.
- R6: After tick k, code 3'b110 gives level k[0], code 3'b101 gives k[1] and code 3'b100 gives k[2]. These are 50% duty waves with periods of 2, 4 and 8 ticks.
- R7: The LED outputs change only in the cycle after a tick. The new level uses the control word and sleep state that are present in the tick cycle.
- R8: With OPEN_DRAIN=1, a high level gives oe=0 and o=0, and a low level gives oe=1 and o=0. With OPEN_DRAIN=0, oe=1 and o equals the level.
- R9: A tick occurs every TICK_DIV clock cycles, first in the TICK_DIV-th cycle after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 7 | [6] program enable, [5:3] power code, [2:0] suspend code |
| sleep_i | input | 2 | Sleep state: 00 working, 01 suspend-to-RAM, 1x soft-off |
| pled_o | output | 1 | Power LED drive value |
| pled_oe_o | output | 1 | Power LED output enable |
| sled_o | output | 1 | Suspend LED drive value |
| sled_oe_o | output | 1 | Suspend LED output enable |

## Verification
A change of control word or sleep state can land in the same cycle as a divider tick, and that cycle also advances the phase. The stimulus changes inputs at random cycles, so some changes fall exactly on a tick cycle and others fall between ticks. A bench model counts cycles since reset to find the tick cycles and applies the inputs sampled there to the incremented phase. The outputs are checked every cycle, so a change that is applied early, late, or with the old phase is reported.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
  localparam int unsigned PHASE_W = 3;

  localparam logic [2:0] PAT_LOW  = 3'b000;
  localparam logic [2:0] PAT_QTR  = 3'b100;
  localparam logic [2:0] PAT_HALF = 3'b101;
  localparam logic [2:0] PAT_1HZ  = 3'b110;
  localparam logic [2:0] PAT_REL  = 3'b111;

  localparam logic [1:0] SLP_WORK = 2'b00;
  localparam logic [1:0] SLP_STR  = 2'b01;

  // level for a pattern code at a given phase; 1 = released
  function automatic logic pat_level(input logic [2:0] code,
                                     input logic [PHASE_W-1:0] ph);
    case (code)
      PAT_REL:  pat_level = 1'b1;
      PAT_1HZ:  pat_level = ph[0];
      PAT_HALF: pat_level = ph[1];
      PAT_QTR:  pat_level = ph[2];
      default:  pat_level = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int unsigned TICK_DIV = 25_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (TICK_DIV > 1) begin : g_gap
      a_r9_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/led_phase_ctr.sv
module led_phase_ctr
  import led_blink_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  output logic [PHASE_W-1:0] phase_nxt_o
);
  logic [PHASE_W-1:0] phase_q;

  assign phase_nxt_o = phase_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (tick_i) phase_q <= phase_nxt_o;
  end
endmodule

// File: rtl/led_src_sel.sv
module led_src_sel
  import led_blink_pkg::*;
(
  input  logic [6:0]         ctrl_i,
  input  logic [1:0]         sleep_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic               pled_lvl_o,
  output logic               sled_lvl_o
);
  logic       prog_en;
  logic [2:0] pcode, scode;
  logic       hw_lvl;

  assign prog_en = ctrl_i[6];
  assign pcode   = ctrl_i[5:3];
  assign scode   = ctrl_i[2:0];

  always_comb begin
    case (sleep_i)
      SLP_WORK: hw_lvl = 1'b0;
      SLP_STR:  hw_lvl = phase_i[0];
      default:  hw_lvl = 1'b1;
    endcase
  end

  always_comb begin
    if (prog_en) begin
      pled_lvl_o = pat_level(pcode, phase_i);
      sled_lvl_o = pat_level(scode, phase_i);
    end else begin
      pled_lvl_o = hw_lvl;
      sled_lvl_o = ~hw_lvl;
    end
  end
endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen
  import led_blink_pkg::*;
#(
  parameter int unsigned TICK_DIV   = 25_000_000,
  parameter bit          OPEN_DRAIN = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [6:0] ctrl_i,
  input  logic [1:0] sleep_i,
  output logic       pled_o,
  output logic       pled_oe_o,
  output logic       sled_o,
  output logic       sled_oe_o
);
  logic               tick;
  logic [PHASE_W-1:0] phase_nxt;
  logic               pled_lvl_d, sled_lvl_d;
  logic               pled_lvl_q, sled_lvl_q;

  led_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  led_phase_ctr u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .phase_nxt_o (phase_nxt)
  );

  led_src_sel u_sel (
    .ctrl_i     (ctrl_i),
    .sleep_i    (sleep_i),
    .phase_i    (phase_nxt),
    .pled_lvl_o (pled_lvl_d),
    .sled_lvl_o (sled_lvl_d)
  );

  // levels move only on a tick: no sub-tick glitches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pled_lvl_q <= 1'b1;
      sled_lvl_q <= 1'b1;
    end else if (tick) begin
      pled_lvl_q <= pled_lvl_d;
      sled_lvl_q <= sled_lvl_d;
    end
  end

  generate
    if (OPEN_DRAIN) begin : g_od
      assign pled_o    = 1'b0;
      assign sled_o    = 1'b0;
      assign pled_oe_o = ~pled_lvl_q;
      assign sled_oe_o = ~sled_lvl_q;
    end else begin : g_pp
      assign pled_o    = pled_lvl_q;
      assign sled_o    = sled_lvl_q;
      assign pled_oe_o = 1'b1;
      assign sled_oe_o = 1'b1;
    end
  endgenerate

  a_r7_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> ($stable(pled_lvl_q) && $stable(sled_lvl_q)));

  a_r2_hw_work_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !ctrl_i[6] && sleep_i == SLP_WORK) |=> (!pled_lvl_q && sled_lvl_q));

  a_r5_release_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && ctrl_i[6] && ctrl_i[5:3] == PAT_REL) |=> pled_lvl_q);

  a_r5_low_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && ctrl_i[6] && ctrl_i[2] == 1'b0) |=> !sled_lvl_q);
endmodule

// File: tb/led_blink_gen_bench.sv
module led_blink_gen_bench;
  localparam int TD = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] ctrl = '0;
  logic [1:0] sleep = '0;
  logic       od_p, od_poe, od_s, od_soe;
  logic       pp_p, pp_poe, pp_s, pp_soe;

  int checks = 0;
  int errs   = 0;

  always #10 clk = ~clk;

  led_blink_gen #(.TICK_DIV(TD), .OPEN_DRAIN(1'b1)) u_led_blink_gen (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_i(ctrl), .sleep_i(sleep),
    .pled_o(od_p), .pled_oe_o(od_poe), .sled_o(od_s), .sled_oe_o(od_soe));

  led_blink_gen #(.TICK_DIV(TD), .OPEN_DRAIN(1'b0)) u_pp (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_i(ctrl), .sleep_i(sleep),
    .pled_o(pp_p), .pled_oe_o(pp_poe), .sled_o(pp_s), .sled_oe_o(pp_soe));

  function automatic logic code_lvl(input logic [2:0] c, input int k);
    case (c)
      3'b111:  return 1'b1;
      3'b110:  return k[0];
      3'b101:  return k[1];
      3'b100:  return k[2];
      default: return 1'b0;
    endcase
  endfunction

  function automatic string code_tag(input logic [2:0] c);
    if (c == 3'b110 || c == 3'b101 || c == 3'b100) return "R4,R6";
    return "R4,R5";
  endfunction

  // reference model: n cycles since reset release, k ticks (R9)
  int    n = 0, k = 0;
  logic  exp_p = 1'b1, exp_s = 1'b1;
  string tag_p = "R1", tag_s = "R1";

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      n = 0; k = 0; exp_p = 1'b1; exp_s = 1'b1; tag_p = "R1"; tag_s = "R1";
    end else begin
      n = n + 1;
      if (n % TD == 0) begin
        k = k + 1;
        if (ctrl[6]) begin
          exp_p = code_lvl(ctrl[5:3], k); tag_p = code_tag(ctrl[5:3]);
          exp_s = code_lvl(ctrl[2:0], k); tag_s = code_tag(ctrl[2:0]);
        end else begin
          exp_p = (sleep == 2'b00) ? 1'b0 : (sleep == 2'b01) ? k[0] : 1'b1;
          exp_s = ~exp_p;
          tag_p = "R2"; tag_s = "R3";
        end
      end
    end
  end

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, n, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      string pre;
      pre = (n % TD == 0) ? "" : "R7 ";
      // R8: open-drain {oe,o} and push-pull {oe,o}
      chk({pre, tag_p, " pled"}, {od_poe, od_p}, {~exp_p, 1'b0});
      chk({pre, tag_s, " sled"}, {od_soe, od_s}, {~exp_s, 1'b0});
      chk("R8 push-pull pled", {pp_poe, pp_p}, {1'b1, exp_p});
      chk("R8 push-pull sled", {pp_soe, pp_s}, {1'b1, exp_s});
    end
  end

  task automatic run(input logic [6:0] c, input logic [1:0] s, input int cyc);
    @(negedge clk);
    ctrl = c; sleep = s;
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    ctrl = 7'h7f; sleep = 2'b00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: released until first tick despite inputs
    repeat (TD - 1) @(negedge clk);
    // R2/R3 hardware mode, all states
    run(7'b0_111_111, 2'b00, 40);
    run(7'b0_000_000, 2'b01, 80);
    run(7'b0_000_000, 2'b10, 40);
    run(7'b0_110_110, 2'b11, 40);
    // R4/R5/R6 programmed codes
    run(7'b1_110_101, 2'b00, 130);
    run(7'b1_100_111, 2'b01, 130);
    run(7'b1_000_001, 2'b10, 40);
    run(7'b1_010_011, 2'b00, 40);
    run(7'b1_111_100, 2'b00, 130);
    // R7: change mid-interval and exactly on tick cycles
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      ctrl  = 7'($urandom);
      sleep = 2'($urandom);
      repeat ($urandom_range(TD * 3)) @(negedge clk);
    end
    // reset mid-run returns to R1 state
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (TD * 4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule